// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single-cycle read and write requests from a 16-bit core into cycles on an external memory bus. It drives an address latch strobe, read and write commands, a chip select, a demultiplexed address output and a shared address/data bus with an output enable. Optionally it also waits on a READY input. All timing comes from a 14-bit configuration register that the core writes. The register sets the wait states, an optional command delay, an optional turnaround state, a stretched address strobe, READY use and polarity, and how the chip select is shaped.

A request starts a cycle only when the core also flags an address-window hit and the bus-enable field is set. A 16-bit bus finishes the word in one cycle. An 8-bit bus runs two byte cycles, low byte first. The block returns read data together with a one-cycle `done` pulse. The register settings are captured when the request is accepted, so a cycle runs with the settings that were present at its start.

When `BOOT_WIN` is set, the register is loaded from strap inputs in the first clock after reset. The bus-type field is copied from the straps. Bus enable and the long strobe are set when the external-access strap is low. All other fields reset to zero.

Top module: `xbus_sequencer`

## Requirements
- R1: During and after reset, `bus_ale`, `bus_rd`, `bus_wr`, `bus_cs`, `bus_ad_oe` and `done` are low, and `rd_data` is zero.
- R2: With `BOOT_WIN`=1, the register is loaded from the straps in the first clock after reset. Bits [7:6] take `strap_btyp`. Bits 9 (bus enable) and 8 (long strobe) are set only when `strap_ext_n` is low. All other bits are zero.
- R3: With READY disabled, the command stays active for (15 − cfg[3:0]) + 1 cycles. A field value of 0 gives 15 wait states and a value of 15 gives none.
- R4: When cfg[4] is 0, one idle cycle with no command follows the strobe. When it is 1, the command starts in the cycle right after the strobe.
- R5: When cfg[5] is 0, one turnaround cycle with no command follows each command. When it is 1, no turnaround cycle is added.
- R6: `bus_ale` is high for one cycle, or for two cycles when cfg[8] is 1. No command is active while `bus_ale` is high.
- R7: A request without `win_hit`, or with cfg[9]=0, produces no strobe and no `done`.
- R8: When cfg[10] is 1, the wait states of R3 elapse first. After that, `bus_rdy` is sampled once per cycle, and the command ends in the first cycle in which `bus_rdy` equals cfg[11].
- R9: When cfg[12] (reads) or cfg[13] (writes) is 1, `bus_cs` is high exactly while the command is active. When the bit is 0, `bus_cs` is high for every cycle of the access.
- R10: cfg[6]=1 selects a multiplexed bus: the address appears on `bus_ad_out`, with `bus_ad_oe` high, while `bus_ale` is high. cfg[6]=0 presents the address on `bus_addr`. `bus_ad_oe` is never high while `bus_rd` is high.
- R11: cfg[7]=0 selects an 8-bit bus. Each access becomes two byte cycles, at the even address and then at the odd address, with data on bits [7:0]. Read bytes are assembled low then high, and `done` follows the second byte cycle.
- R12: `done` is a single-cycle pulse in the cycle after the access's last state, and `rd_data` holds the read word at that time. Write data is driven on `bus_ad_out`, with `bus_ad_oe` high, during the write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 14 | Configuration register write value |
| strap_btyp | input | 2 | Bus type strap, loaded after reset |
| strap_ext_n | input | 1 | External-access strap, active low |
| req | input | 1 | One-cycle access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write word |
| win_hit | input | 1 | Address-window hit for this request |
| rd_data | output | DW | Read word, valid with `done` |
| done | output | 1 | Access-complete pulse |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read command, active high |
| bus_wr | output | 1 | Write command, active high |
| bus_cs | output | 1 | Chip select, active high |
| bus_addr | output | AW | Demultiplexed address |
| bus_ad_out | output | DW | Shared bus output value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_ad_in | input | DW | Shared bus input value |
| bus_rdy | input | 1 | READY input |

## Verification
The request is sampled at clock edge E0, and the strobe is visible in the cycle that follows. With L command cycles, the `done` pulse is due T cycles after E0 for one byte cycle, where T = 1 + cfg[8] + (1 − cfg[4]) + L + (1 − cfg[5]); an 8-bit access is due after twice that. The first command is due 2 + cfg[8] + (1 − cfg[4]) cycles after E0. The bench samples at falling edges and counts cycles from the edge that accepts the request. For every access it compares the measured `done` latency, the first-command cycle, and the strobe, command and chip-select cycle counts against values it computes from the configuration. Read data is checked at the `done` cycle. The bench's READY driver goes active after a chosen number of command cycles, which makes the expected command length max(15 − cfg[3:0], hold) + 1.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

  localparam int unsigned WFIELD_W = 4;

  typedef enum logic [1:0] {
    BT_DEMUX8  = 2'b00,
    BT_MUX8    = 2'b01,
    BT_DEMUX16 = 2'b10,
    BT_MUX16   = 2'b11
  } btype_e;

  // bit 0 of btyp: multiplexed, bit 1: 16-bit wide
  typedef struct packed {
    logic                cs_wr_cmd;  // [13]
    logic                cs_rd_cmd;  // [12]
    logic                rdy_pol;    // [11]
    logic                rdy_en;     // [10]
    logic                bus_en;     // [9]
    logic                ale_long;   // [8]
    btype_e              btyp;       // [7:6]
    logic                tri_skip;   // [5]
    logic                dly_skip;   // [4]
    logic [WFIELD_W-1:0] wfield;     // [3:0]
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_ALE2,
    ST_DLY,
    ST_CMD,
    ST_TRI
  } state_e;

endpackage

// File: rtl/xbus_cfg_reg.sv
`timescale 1ns/1ps
module xbus_cfg_reg
  import xbus_pkg::*;
#(
  parameter bit BOOT_WIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cfg_t       wdata,
  input  logic [1:0] strap_btyp,
  input  logic       strap_ext_n,
  output cfg_t       cfg
);

  cfg_t cfg_q, cfg_d;
  logic boot_pend_q;

  always_comb begin
    cfg_d = cfg_q;
    if (BOOT_WIN && boot_pend_q) begin
      cfg_d.btyp = btype_e'(strap_btyp);
      if (!strap_ext_n) begin
        cfg_d.bus_en   = 1'b1;
        cfg_d.ale_long = 1'b1;
      end
    end else if (wr_en) begin
      cfg_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      boot_pend_q <= 1'b1;
    end else begin
      cfg_q       <= cfg_d;
      boot_pend_q <= 1'b0;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/xbus_wait_cnt.sv
`timescale 1ns/1ps
module xbus_wait_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cfg_t                cfg,
  input  logic                req,
  input  logic                req_we,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                win_hit,
  input  logic [DW-1:0]       ad_in,
  input  logic                rdy_in,
  input  logic                wait_zero,
  output logic                wait_load,
  output logic [WFIELD_W-1:0] wait_val,
  output logic                wait_dec,
  output logic                bus_ale,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic                bus_cs,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       ad_out,
  output logic                ad_oe,
  output logic [DW-1:0]       rd_data,
  output logic                done
);

  localparam int unsigned BW = DW / 2;

  state_e          st_q, st_d;
  cfg_t            acc_q, acc_d;
  logic            we_q, we_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   wd_q, wd_d;
  logic [DW-1:0]   rdat_q, rdat_d;
  logic            hi_q, hi_d;
  logic            done_q, done_d;

  logic            wide, muxed, rdy_ok, byte_end, start;
  logic            act, in_cmd, in_ale, cs_by_cmd;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   wsel;

  always_comb begin
    wide   = acc_q.btyp[1];
    muxed  = acc_q.btyp[0];
    rdy_ok = !acc_q.rdy_en || (rdy_in == acc_q.rdy_pol);
    start  = req && win_hit && cfg.bus_en;
  end

  // next-state process
  always_comb begin
    st_d     = st_q;
    acc_d    = acc_q;
    we_d     = we_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    rdat_d   = rdat_q;
    hi_d     = hi_q;
    done_d   = 1'b0;
    wait_dec = 1'b0;
    byte_end = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_ALE;
          acc_d  = cfg;
          we_d   = req_we;
          addr_d = req_addr;
          wd_d   = req_wdata;
          hi_d   = 1'b0;
        end
      end
      ST_ALE: begin
        if (acc_q.ale_long)      st_d = ST_ALE2;
        else if (acc_q.dly_skip) st_d = ST_CMD;
        else                     st_d = ST_DLY;
      end
      ST_ALE2: st_d = acc_q.dly_skip ? ST_CMD : ST_DLY;
      ST_DLY:  st_d = ST_CMD;
      ST_CMD: begin
        if (!wait_zero) begin
          wait_dec = 1'b1;
        end else if (rdy_ok) begin
          if (!we_q) begin
            if (wide)      rdat_d          = ad_in;
            else if (hi_q) rdat_d[DW-1:BW] = ad_in[BW-1:0];
            else           rdat_d[BW-1:0]  = ad_in[BW-1:0];
          end
          if (acc_q.tri_skip) byte_end = 1'b1;
          else                st_d     = ST_TRI;
        end
      end
      ST_TRI:  byte_end = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (byte_end) begin
      if (wide || hi_q) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        hi_d = 1'b1;
        st_d = ST_ALE;
      end
    end
  end

  assign wait_load = (st_d == ST_CMD) && (st_q != ST_CMD);
  assign wait_val  = ~acc_q.wfield;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rdat_q <= '0;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      acc_q  <= acc_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rdat_q <= rdat_d;
      hi_q   <= hi_d;
      done_q <= done_d;
    end
  end

  // output decode
  always_comb begin
    act       = (st_q != ST_IDLE);
    in_cmd    = (st_q == ST_CMD);
    in_ale    = (st_q == ST_ALE) || (st_q == ST_ALE2);
    cs_by_cmd = we_q ? acc_q.cs_wr_cmd : acc_q.cs_rd_cmd;
    cur_addr  = wide ? addr_q : {addr_q[AW-1:1], hi_q};
    wsel      = wide ? wd_q
                     : {{(DW-BW){1'b0}}, (hi_q ? wd_q[DW-1:BW] : wd_q[BW-1:0])};
  end

  assign bus_ale  = in_ale;
  assign bus_rd   = in_cmd && !we_q;
  assign bus_wr   = in_cmd && we_q;
  assign bus_cs   = cs_by_cmd ? in_cmd : act;
  assign bus_addr = act ? cur_addr : '0;
  assign ad_out   = (muxed && in_ale) ? DW'(cur_addr) : wsel;
  assign ad_oe    = (muxed && in_ale) || (we_q && ((st_q == ST_DLY) || in_cmd));
  assign rd_data  = rdat_q;
  assign done     = done_q;

endmodule

// File: rtl/xbus_sequencer.sv
`timescale 1ns/1ps
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter bit          BOOT_WIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [1:0]       strap_btyp,
  input  logic             strap_ext_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             win_hit,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             bus_ale,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_cs,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [DW-1:0]    bus_ad_in,
  input  logic             bus_rdy
);

  logic [1:0]          rst_pipe;
  logic                rst_int;
  cfg_t                cfg;
  logic                wait_load, wait_dec, wait_zero;
  logic [WFIELD_W-1:0] wait_val;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  xbus_cfg_reg #(.BOOT_WIN(BOOT_WIN)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_int),
    .wr_en       (cfg_we),
    .wdata       (cfg_t'(cfg_wdata)),
    .strap_btyp  (strap_btyp),
    .strap_ext_n (strap_ext_n),
    .cfg         (cfg)
  );

  xbus_wait_cnt #(.W(WFIELD_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_int),
    .load     (wait_load),
    .load_val (wait_val),
    .dec      (wait_dec),
    .zero     (wait_zero)
  );

  xbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int),
    .cfg       (cfg),
    .req       (req),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .win_hit   (win_hit),
    .ad_in     (bus_ad_in),
    .rdy_in    (bus_rdy),
    .wait_zero (wait_zero),
    .wait_load (wait_load),
    .wait_val  (wait_val),
    .wait_dec  (wait_dec),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_cs    (bus_cs),
    .bus_addr  (bus_addr),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .rd_data   (rd_data),
    .done      (done)
  );

endmodule

// File: rtl/xbus_sequencer_chk.sv
`timescale 1ns/1ps
module xbus_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ale,
  input logic bus_rd,
  input logic bus_wr,
  input logic bus_cs,
  input logic bus_ad_oe,
  input logic done
);

  assert_no_cmd_in_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !(bus_rd || bus_wr));

  assert_cs_covers_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_cs);

  assert_bus_released_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_ad_oe);

  assert_write_drives_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_ad_oe);

  assert_rd_wr_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind xbus_sequencer xbus_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ale   (bus_ale),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_cs    (bus_cs),
  .bus_ad_oe (bus_ad_oe),
  .done      (done)
);

// File: tb/xbus_sequencer_test.sv
`timescale 1ns/1ps
module xbus_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic [1:0]  strap_btyp = 2'b00;
  logic        strap_ext_n = 1'b1;
  logic        req = 1'b0, req_we = 1'b0, win_hit = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [15:0] rd_data, bus_addr, bus_ad_out;
  logic [15:0] bus_ad_in = '0;
  logic        done, bus_ale, bus_rd, bus_wr, bus_cs, bus_ad_oe;
  logic        bus_rdy = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xbus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .strap_btyp(strap_btyp), .strap_ext_n(strap_ext_n),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .win_hit(win_hit), .rd_data(rd_data), .done(done),
    .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cs(bus_cs),
    .bus_addr(bus_addr), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_rdy(bus_rdy)
  );

  // bench view of the configuration and bus model state
  logic [13:0] cur_cfg = '0;
  int          cur_hold = 0;
  logic [15:0] lat = '0;
  int          cmd_seen = 0;
  int          ale_cnt, cmd_cnt, cs_cnt, first_cmd, viol, nwr;
  logic        prev_wr;
  logic [15:0] wa [2];
  logic [15:0] wd [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem16(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] mem8(input logic [15:0] a);
    logic [15:0] w;
    w = mem16({a[15:1], 1'b0});
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic int cmd_len(input logic [13:0] c, input int hold);
    int l;
    l = 15 - int'(c[3:0]) + 1;
    if (c[10] && (hold + 1 > l)) l = hold + 1;
    return l;
  endfunction

  function automatic int byte_len(input logic [13:0] c, input int hold);
    return 1 + int'(c[8]) + (c[4] ? 0 : 1) + cmd_len(c, hold) + (c[5] ? 0 : 1);
  endfunction

  task automatic set_cfg(input logic [13:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = c;
  endtask

  task automatic do_reset(input logic ext_n, input logic [1:0] bt);
    strap_ext_n = ext_n; strap_btyp = bt;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // per-cycle observation at the falling edge; sets bus inputs for the next edge
  task automatic mon(input int n);
    ale_cnt += int'(bus_ale);
    cmd_cnt += int'(bus_rd || bus_wr);
    cs_cnt  += int'(bus_cs);
    if (first_cmd == 0 && (bus_rd || bus_wr)) first_cmd = n;
    if ((bus_rd && bus_ad_oe) || (bus_wr && !bus_ad_oe)) viol++;
    if (bus_wr && !prev_wr && nwr < 2) begin
      wa[nwr] = lat; wd[nwr] = bus_ad_out; nwr++;
    end
    prev_wr = bus_wr;
    if (bus_ale) begin
      lat = cur_cfg[6] ? bus_ad_out : bus_addr;
      cmd_seen = 0;
    end
    if (bus_rd || bus_wr) cmd_seen++;
    bus_rdy   = (cmd_seen >= cur_hold + 1) ? cur_cfg[11] : ~cur_cfg[11];
    bus_ad_in = cur_cfg[7] ? mem16(lat) : {8'hEE, mem8(lat)};
  endtask

  task automatic run_access(input logic we, input logic [15:0] a, input logic [15:0] d,
                            input int hold);
    int bytes, bl, l, busy, exp_busy;
    logic seen;
    logic [15:0] got;
    logic [15:0] exp_rd;
    cur_hold = hold;
    bytes = cur_cfg[7] ? 1 : 2;
    l  = cmd_len(cur_cfg, hold);
    bl = byte_len(cur_cfg, hold);
    exp_busy = bytes * bl;
    ale_cnt = 0; cmd_cnt = 0; cs_cnt = 0; first_cmd = 0; viol = 0; nwr = 0;
    prev_wr = 1'b0; seen = 1'b0; busy = 0; got = '0;
    bus_rdy = ~cur_cfg[11];
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; win_hit = 1'b1;
    @(negedge clk);
    req = 1'b0; win_hit = 1'b0;
    for (int n = 1; n <= 600 && !seen; n++) begin
      if (n > 1) @(negedge clk);
      mon(n);
      if (done) begin
        seen = 1'b1; busy = n - 1; got = rd_data;
      end
    end
    chk("R3 R5 R11 done latency", busy, exp_busy);
    chk("R4 first command cycle", first_cmd, 2 + int'(cur_cfg[8]) + (cur_cfg[4] ? 0 : 1));
    chk("R6 strobe cycles", ale_cnt, bytes * (1 + int'(cur_cfg[8])));
    chk("R3 R8 command cycles", cmd_cnt, bytes * l);
    chk("R9 chip select cycles", cs_cnt,
        (we ? cur_cfg[13] : cur_cfg[12]) ? bytes * l : exp_busy);
    chk("R10 R12 bus enable rule", viol, 0);
    if (!we) begin
      exp_rd = cur_cfg[7] ? mem16(a) : mem16({a[15:1], 1'b0});
      chk(cur_cfg[7] ? "R12 read data" : "R11 byte read data", got, exp_rd);
    end else if (cur_cfg[7]) begin
      chk("R12 write count", nwr, 1);
      chk("R10 R12 write address", wa[0], a);
      chk("R12 write data", wd[0], d);
    end else begin
      chk("R11 byte write count", nwr, 2);
      chk("R11 byte addresses", {wa[0], wa[1]}, {a[15:1], 1'b0, a[15:1], 1'b1});
      chk("R11 byte write data", {wd[1][7:0], wd[0][7:0]}, d);
    end
  endtask

  task automatic run_ignored(input logic hit, input string tag);
    int ales, dones;
    ales = 0; dones = 0;
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 16'h0042; win_hit = hit;
    @(negedge clk);
    req = 1'b0; win_hit = 1'b0;
    repeat (40) begin
      ales  += int'(bus_ale);
      dones += int'(done);
      @(negedge clk);
    end
    chk({tag, " no strobe"}, ales, 0);
    chk({tag, " no done"}, dones, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] c;
    int hold;
    void'($urandom(32'd1357));
    // R1: reset state (straps give an all-zero register)
    do_reset(1'b1, 2'b00);
    chk("R1 idle outputs", {bus_ale, bus_rd, bus_wr, bus_cs, bus_ad_oe, done}, 6'b0);
    chk("R1 read data cleared", rd_data, 16'h0000);
    cur_cfg = 14'h0000;
    run_ignored(1'b1, "R1 R7 zero register");

    // R3 R4 R5 R11: slowest timing on an 8-bit demultiplexed bus
    set_cfg(14'h0200);
    run_access(1'b0, 16'h0100, 16'h0, 0);
    run_access(1'b1, 16'h0203, 16'hBEEF, 0);

    // fastest 16-bit multiplexed bus: no waits, no delay, no turnaround
    set_cfg(14'h02FF);
    run_access(1'b0, 16'h1234, 16'h0, 0);
    run_access(1'b1, 16'h4321, 16'hA55A, 0);
    // R6 long strobe with command delay, 8-bit multiplexed
    set_cfg(14'h0140 | 14'h0200 | 14'h000D);
    run_access(1'b0, 16'h7FFE, 16'h0, 0);
    run_access(1'b1, 16'h0010, 16'h1357, 0);

    // R8: READY after programmed waits, both polarities
    set_cfg(14'h02FC | 14'h0400);
    run_access(1'b0, 16'h0AA0, 16'h0, 30);
    run_access(1'b1, 16'h0AA2, 16'h2468, 1);
    set_cfg(14'h02FC | 14'h0C00);
    run_access(1'b0, 16'h0BB0, 16'h0, 25);
    // R9: chip select follows the command
    set_cfg(14'h02B9 | 14'h3000);
    run_access(1'b0, 16'h0C00, 16'h0, 0);
    run_access(1'b1, 16'h0C02, 16'hF00D, 0);

    // R7: no window hit, and bus disabled
    set_cfg(14'h02FF);
    run_ignored(1'b0, "R7 no hit");
    set_cfg(14'h00FF);
    run_ignored(1'b1, "R7 bus disabled");

    // random configurations and accesses
    for (int i = 0; i < 40; i++) begin
      c = 14'($urandom()) | 14'h0200;
      hold = int'($urandom_range(0, 20));
      set_cfg(c);
      run_access(1'($urandom()), 16'($urandom()), 16'($urandom()), hold);
    end

    // R2: boot straps, external access low, 16-bit demultiplexed
    do_reset(1'b0, 2'b10);
    cur_cfg = 14'h0380;
    run_access(1'b0, 16'h1234, 16'h0, 0);
    checks++;
    if (ale_cnt != 2) begin
      errors++;
      $display("FAIL R2 strapped long strobe: actual %0d expected 2", ale_cnt);
    end
    // R2: external access high leaves bus disabled
    do_reset(1'b1, 2'b11);
    cur_cfg = 14'h00C0;
    run_ignored(1'b1, "R2 strap bus disabled");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule